// File: doc/BRIEF.md
# Programmable LED Blink Controller

The block drives one LED output from an 8-bit control byte that a host writes. The byte selects one of three behaviours: the output held low, the output held high, or a repeating short flash. In flash mode the LED turns on at the start of every period and stays on for a programmable number of milliseconds. The period and the on-time each come from a two-bit field. All timing counts a one-millisecond tick enable that is supplied from outside, so the block needs no knowledge of the clock frequency.

The same byte carries a one-shot request that clears a bus error counter elsewhere in the chip. Writing that bit as 1 produces a single-cycle pulse on a dedicated output. The bit is not stored. One bit of the byte has no function.

Top module: `led_blink_ctrl`

## Requirements
- R1: Function field bits 7:6 = 00 holds `led` at 0, and 10 holds `led` at 1, for as long as the setting stays.
- R2: Function codes 01 and 11 both select flashing, and they give the same on-time and period for equal bits 3:0.
- R3: In flash mode, bits 3:2 set the period in `ms_tick` counts: 00 = 500, 01 = 1000, 10 = 1500, 11 = 2000.
- R4: In flash mode, bits 1:0 set the on-time at the start of each period in `ms_tick` counts: 00 = 20, 01 = 30, 10 = 40, 11 = 50. `led` is 0 for the rest of the period.
- R5: Writing bit 4 as 1 gives `err_clr` high for exactly the one cycle after the write. A write with bit 4 = 0 gives no pulse, whatever bit 5 holds. Bit 5 has no effect on `led`.
- R6: After synchronous reset the register value is 04h: `led` is 0 and stays 0 while ticks run, and `err_clr` is 0.
- R7: A write that selects flashing restarts the phase. `led` is 1 in the cycle after the write and stays on for the full on-time.
- R8: The phase advances only on cycles with `ms_tick` high. Without ticks, `led` holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle enable, once per millisecond |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control byte to write |
| led | output | 1 | LED drive level |
| err_clr | output | 1 | One-cycle pulse that clears the bus error counter |

## Verification
The assertions take for granted that `wr_en` is low while `rst` is high. They also assume that a write occupies a single cycle. The bench drives every write for exactly one cycle and holds the strobe low through reset. In most runs it keeps `ms_tick` high on every cycle, so that periods of up to 2000 ticks stay short in cycles. It drops the tick only in the directed stall test.

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl #(
  parameter int CNT_W       = 11,
  parameter int PERIOD_STEP = 500,
  parameter int ON_BASE     = 20,
  parameter int ON_STEP     = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       led,
  output logic       err_clr
);

  logic [1:0]       func_q, per_q, on_q;
  logic [CNT_W-1:0] cnt_q, period_ms, on_ms;
  logic             blink;

  assign period_ms = CNT_W'(PERIOD_STEP * (32'(per_q) + 1));
  assign on_ms     = CNT_W'(ON_BASE + ON_STEP * 32'(on_q));
  assign blink     = func_q[0];
  assign led       = (func_q == 2'b10) || (blink && (cnt_q < on_ms));

  always_ff @(posedge clk) begin
    if (rst) begin
      func_q  <= 2'b00;
      per_q   <= 2'b01;
      on_q    <= 2'b00;
      err_clr <= 1'b0;
    end else begin
      err_clr <= wr_en && wr_data[4];
      if (wr_en) begin
        func_q <= wr_data[7:6];
        per_q  <= wr_data[3:2];
        on_q   <= wr_data[1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || wr_en || !blink)
      cnt_q <= '0;
    else if (ms_tick)
      cnt_q <= (cnt_q == period_ms - 1'b1) ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    cnt_q < period_ms);                                              // R3
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ms_tick && !wr_en) |=> $stable(cnt_q) && $stable(led));        // R8
  AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err_clr |-> $past(wr_en && wr_data[4]));                         // R5
  AST_CLR_NOT_B5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[5] && !wr_data[4]) |=> !err_clr);              // R5
  AST_BLINK_RESTART: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[6]) |=> led);                                  // R7
  AST_FORCED_LOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[7:6] == 2'b00) |=> !led);                      // R1
  AST_FORCED_HIGH: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[7:6] == 2'b10) |=> led);                       // R1

endmodule

// File: tb/tb_led_blink_ctrl.sv
module tb_led_blink_ctrl;
  logic clk = 0, rst = 1, ms_tick = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic led, err_clr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  led_blink_ctrl dut (.clk(clk), .rst(rst), .ms_tick(ms_tick), .wr_en(wr_en),
                      .wr_data(wr_data), .led(led), .err_clr(err_clr));

  // {byte, on-time (or static level), period (0 = static)}
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    {8'h44, 12'd20, 12'd1000}, {8'hC4, 12'd20, 12'd1000},
    {8'hC3, 12'd50, 12'd500},  {8'h43, 12'd50, 12'd500},
    {8'h6E, 12'd40, 12'd2000}, {8'h49, 12'd30, 12'd1500},
    {8'hCD, 12'd30, 12'd2000}, {8'h00, 12'd0,  12'd0},
    {8'h80, 12'd1,  12'd0},    {8'hA7, 12'd1,  12'd0}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic measure(output int on_t, output int per);
    int idx = 0;
    on_t = 0;
    while (led && idx < 3000) begin on_t++; idx++; @(negedge clk); end
    while (!led && idx < 3000) begin idx++; @(negedge clk); end
    per = idx;
  endtask

  initial begin
    int on_t, per, bad;
    ms_tick = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R6 led after reset", led, 0);
    chk("R6 err_clr after reset", err_clr, 0);
    bad = 0;
    repeat (2100) begin @(negedge clk); if (led) bad++; end
    chk("R6 led stays low with ticks", bad, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][31:24]);
      if (VEC[i][11:0] == 0) begin
        bad = 0;
        for (int k = 0; k < 2100; k++) begin
          if (led != VEC[i][12]) bad++;
          @(negedge clk);
        end
        chk($sformatf("R1 R5 static level, byte %h mismatching cycles", VEC[i][31:24]), bad, 0);
      end else begin
        measure(on_t, per);
        chk($sformatf("R4 R2 on-time, byte %h", VEC[i][31:24]), on_t, int'(VEC[i][23:12]));
        chk($sformatf("R3 R2 period, byte %h", VEC[i][31:24]), per, int'(VEC[i][11:0]));
      end
    end

    // R5 clear pulse
    wr(8'h10);
    chk("R5 err_clr pulse after write", err_clr, 1);
    chk("R5 led stays low with bit 4", led, 0);
    @(negedge clk);
    chk("R5 err_clr one cycle only", err_clr, 0);
    wr(8'hA0);
    chk("R5 no pulse with bit 4 clear", err_clr, 0);
    chk("R5 bit 5 no effect, held high", led, 1);

    // R8 no ticks, no progress
    ms_tick = 0;
    wr(8'h44);
    bad = 0;
    repeat (200) begin @(negedge clk); if (!led) bad++; end
    chk("R8 led holds without ticks", bad, 0);
    ms_tick = 1;
    measure(on_t, per);
    chk("R8 on-time after ticks resume", on_t, 20);

    // R7 restart mid-period
    wr(8'hC3);
    repeat (100) @(negedge clk);
    chk("R7 led low mid-period", led, 0);
    wr(8'hC3);
    measure(on_t, per);
    chk("R7 full on-time after rewrite", on_t, 50);
    chk("R7 period after rewrite", per, 500);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule